// File: doc/BRIEF.md
# Relocatable Host Memory Overlay Window

This block sits between an 8-bit host expansion bus with a 16-bit address and one port of a buffer RAM. The other port of that RAM is filled by a companion controller. Host software can place a window anywhere in the host address space. Inside that window, the buffer RAM takes the place of the host's internal RAM. Host reads return buffer bytes, and host writes land in the buffer. While the host accesses the window, the block pulls an active-low override line to suppress the internal RAM. Data that the companion controller writes into the buffer therefore appears directly in host memory, for example as display memory.

Three host-visible registers define the window:

- a lower bound;
- an upper bound;
- a control byte that holds an enable bit and an index-width field.

The registers sit in the device's own I/O window at $D800–$DFFF. That window keeps working whatever the overlay settings are. Nothing responds until the host sets the device-select bit at $D1FF.

The host bus is modelled synchronously. `bus_valid` marks the single-cycle data phase of a host access.

Top module: `hwo_overlay`

## Requirements
- R1: After reset, every register reads zero, the device is deselected and the overlay is disabled. While idle, `ext_sel_n` is 1, `bus_oe` is 0 and `buf_we` is 0.
- R2: A host write to $D1FF copies data bit 0 into the device-select flag. While this flag is 0:
  - the block asserts no output;
  - register writes in the device window are ignored.
- R3: A bound register is written in two steps. The low byte goes to the even offset and is only staged. The high byte goes to the next offset and commits the full 16-bit value. The device-window offsets are: lower bound 0 (low byte) and 1 (high byte), upper bound 2 and 3, control 4. Reading offset 0 or 2 returns the committed low byte.
- R4: An address hits the window when lower <= address < upper, compared unsigned. When upper <= lower, the window is empty.
- R5: The buffer index is (address − lower) ANDed with a mask. The mask has its k+1 lowest bits set, where k is control bits [3:0]. Index bits above the mask are zero.
- R6: A host read that hits an enabled window does three things in the same cycle as `bus_valid`: it drives `ext_sel_n` low, sets `bus_oe` high, and returns the buffer RAM byte at the index on `bus_rdata`.
- R7: A host write that hits an enabled window raises `buf_we` for exactly its one data-phase cycle. It presents the index on `buf_addr` and the bus byte on `buf_wdata`. `bus_oe` stays low during writes.
- R8: Control bit 7 enables the overlay. With this bit clear, no address outside the device window asserts `ext_sel_n`.
- R9: While the device is selected, any access to $D800–$DFFF drives `ext_sel_n` low, and a read there also sets `bus_oe`. This device window takes priority over an overlapping overlay window. Register offsets return their register, other offsets read 0, and no buffer write occurs.
- R10: While `bus_valid` is low, `ext_sel_n` is 1, `bus_oe` is 0 and `buf_we` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus-synchronous clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Data phase of a host access is valid |
| bus_rw | input | 1 | 1 = host read, 0 = host write |
| bus_addr | input | 16 | Host address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Data returned to the host |
| bus_oe | output | 1 | Host data bus output enable |
| ext_sel_n | output | 1 | Active-low internal RAM override |
| buf_addr | output | 14 | Buffer RAM index |
| buf_we | output | 1 | Buffer RAM write strobe |
| buf_wdata | output | 8 | Buffer RAM write data |
| buf_rdata | input | 8 | Buffer RAM read data (combinational port) |

## Verification
The bus-facing outputs `ext_sel_n`, `bus_oe`, `bus_rdata`, `buf_addr`, `buf_we` and `buf_wdata` decode combinationally, so they are due in the same cycle that `bus_valid` is high. A register or device-select write takes effect at the clock edge that closes its data phase, so it shows from the next access onwards. The driver raises each access one time unit after a rising edge and holds it for one full cycle. The monitor compares at the falling edge inside that cycle. Every access is separated by an idle cycle, so each register update has settled before the access that observes it.

// File: rtl/hwo_pkg.sv
// Package hwo_pkg: shared constants for the host memory overlay block.
// Assumes an 8-bit data bus and byte-wide register offsets.
package hwo_pkg;
    localparam int REG_COUNT = 5;

    typedef enum logic [2:0] {
        OFS_LOW_LO = 3'd0,
        OFS_LOW_HI = 3'd1,
        OFS_UP_LO  = 3'd2,
        OFS_UP_HI  = 3'd3,
        OFS_CTRL   = 3'd4
    } reg_ofs_e;

    localparam int CTRL_EN_BIT = 7;
    localparam int CTRL_WID_W  = 4;
endpackage

// File: rtl/hwo_regs.sv
// Module hwo_regs: device-select flag and the window register file.
// Assumes the top has already decided that the access falls in the device
// window (dev_win). Bounds are staged low byte first; the high-byte write
// commits. All state resets synchronously to zero.
module hwo_regs
    import hwo_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          DATA_W  = 8,
    parameter int          DEV_BIT = 0,
    parameter logic [15:0] SEL_ADDR = 16'hD1FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_rw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              dev_win,
    output logic              dev_sel,
    output logic [ADDR_W-1:0] low_bound,
    output logic [ADDR_W-1:0] up_bound,
    output logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] reg_rdata
);
    logic [DATA_W-1:0] low_stage_q, up_stage_q;
    logic              reg_wr, sel_wr;
    logic              wr_low_hi, wr_up_hi;
    logic [2:0]        ofs;
    logic              ofs_ok;

    // Decode register offset and write qualifiers.
    always_comb begin
        ofs       = bus_addr[2:0];
        ofs_ok    = (bus_addr[ADDR_W-6:3] == '0) && (int'(ofs) < REG_COUNT);
        reg_wr    = bus_valid && !bus_rw && dev_sel && dev_win && ofs_ok;
        sel_wr    = bus_valid && !bus_rw && (bus_addr == SEL_ADDR);
        wr_low_hi = reg_wr && (ofs == OFS_LOW_HI);
        wr_up_hi  = reg_wr && (ofs == OFS_UP_HI);
    end

    // Device-select flag follows the chosen data bit of a select write.
    always_ff @(posedge clk) begin
        if (!rst_n)      dev_sel <= 1'b0;
        else if (sel_wr) dev_sel <= bus_wdata[DEV_BIT];
    end

    // Register file: stage low bytes, commit on high byte, control direct.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_stage_q <= '0;
            up_stage_q  <= '0;
            low_bound   <= '0;
            up_bound    <= '0;
            ctrl        <= '0;
        end else if (reg_wr) begin
            case (ofs)
                OFS_LOW_LO: low_stage_q <= bus_wdata;
                OFS_LOW_HI: low_bound   <= {bus_wdata, low_stage_q};
                OFS_UP_LO:  up_stage_q  <= bus_wdata;
                OFS_UP_HI:  up_bound    <= {bus_wdata, up_stage_q};
                OFS_CTRL:   ctrl        <= bus_wdata;
                default:    ;
            endcase
        end
    end

    // Register readback; unused offsets read zero.
    always_comb begin
        reg_rdata = '0;
        if (ofs_ok) begin
            case (ofs)
                OFS_LOW_LO: reg_rdata = low_bound[DATA_W-1:0];
                OFS_LOW_HI: reg_rdata = low_bound[ADDR_W-1:DATA_W];
                OFS_UP_LO:  reg_rdata = up_bound[DATA_W-1:0];
                OFS_UP_HI:  reg_rdata = up_bound[ADDR_W-1:DATA_W];
                OFS_CTRL:   reg_rdata = ctrl;
                default:    reg_rdata = '0;
            endcase
        end
    end

    AST_LOW_COMMIT_ON_HI: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(low_bound) |-> $past(wr_low_hi)); // R3
    AST_UP_COMMIT_ON_HI: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(up_bound) |-> $past(wr_up_hi)); // R3
    AST_CTRL_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> $past(dev_sel)); // R2
endmodule

// File: rtl/hwo_window.sv
// Module hwo_window: window hit test and masked buffer index.
// Assumes bounds are unsigned with an exclusive upper bound; the mask keeps
// the lowest (width+1) index bits and is clipped to the buffer width.
module hwo_window
    import hwo_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BUF_AW = 14
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [ADDR_W-1:0]     low_bound,
    input  logic [ADDR_W-1:0]     up_bound,
    input  logic                  enable,
    input  logic [CTRL_WID_W-1:0] width,
    output logic                  hit,
    output logic [BUF_AW-1:0]     index
);
    logic [BUF_AW-1:0] diff;
    logic [BUF_AW-1:0] mask;

    // Unsigned half-open range test, gated by the enable bit.
    always_comb begin
        hit = enable && (addr >= low_bound) && (addr < up_bound);
    end

    // Build the index mask bit by bit from the width field.
    always_comb begin
        for (int i = 0; i < BUF_AW; i++) begin
            mask[i] = (i <= int'(width));
        end
    end

    // Offset into the window, then masked.
    always_comb begin
        diff  = addr[BUF_AW-1:0] - low_bound[BUF_AW-1:0];
        index = diff & mask;
    end
endmodule

// File: rtl/hwo_overlay.sv
// Module hwo_overlay: top of the relocatable host memory overlay.
// Assumes a synchronous host bus in which bus_valid marks a single-cycle data
// phase, and a buffer RAM port with a combinational read. The device window
// (DEV_BASE, 2**DEV_LOG2 bytes) has priority over the overlay.
module hwo_overlay
    import hwo_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          BUF_AW   = 14,
    parameter logic [15:0] DEV_BASE = 16'hD800,
    parameter int          DEV_LOG2 = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_rw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_oe,
    output logic              ext_sel_n,
    output logic [BUF_AW-1:0] buf_addr,
    output logic              buf_we,
    output logic [DATA_W-1:0] buf_wdata,
    input  logic [DATA_W-1:0] buf_rdata
);
    localparam int TAG_W = ADDR_W - DEV_LOG2;

    logic              dev_win, dev_sel, win_hit, claim;
    logic [ADDR_W-1:0] low_bound, up_bound;
    logic [DATA_W-1:0] ctrl, reg_rdata;
    logic [BUF_AW-1:0] index;

    // Device window decode on the upper address bits.
    always_comb begin
        dev_win = (bus_addr[ADDR_W-1:DEV_LOG2] == DEV_BASE[ADDR_W-1:ADDR_W-TAG_W]);
    end

    hwo_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_rw    (bus_rw),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .dev_win   (dev_win),
        .dev_sel   (dev_sel),
        .low_bound (low_bound),
        .up_bound  (up_bound),
        .ctrl      (ctrl),
        .reg_rdata (reg_rdata)
    );

    hwo_window #(.ADDR_W(ADDR_W), .BUF_AW(BUF_AW)) u_window (
        .addr      (bus_addr),
        .low_bound (low_bound),
        .up_bound  (up_bound),
        .enable    (ctrl[CTRL_EN_BIT]),
        .width     (ctrl[CTRL_WID_W-1:0]),
        .hit       (win_hit),
        .index     (index)
    );

    // Bus-side response: claim the access, override internal RAM, route data.
    always_comb begin
        claim     = bus_valid && dev_sel && (dev_win || win_hit);
        ext_sel_n = !claim;
        bus_oe    = claim && bus_rw;
        bus_rdata = dev_win ? reg_rdata : buf_rdata;
    end

    // Buffer-side write strobe for overlay writes outside the device window.
    always_comb begin
        buf_addr  = index;
        buf_wdata = bus_wdata;
        buf_we    = bus_valid && !bus_rw && dev_sel && win_hit && !dev_win;
    end

    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_valid && bus_rw && !ext_sel_n)); // R6
    AST_WE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (bus_valid && !bus_rw && !bus_oe && !ext_sel_n)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (ext_sel_n && !bus_oe && !buf_we)); // R10
    AST_SEL_NEEDS_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_sel_n |-> dev_sel); // R2
    AST_DEVWIN_NO_BUFWR: assert property (@(posedge clk) disable iff (!rst_n)
        dev_win |-> !buf_we); // R9
endmodule

// File: tb/hwo_overlay_test.sv
// Scoreboard bench for hwo_overlay: driver tasks push expected responses,
// a falling-edge monitor pops and compares during each data phase.
module hwo_overlay_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_rw = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_oe, ext_sel_n, buf_we;
    logic [13:0] buf_addr;
    logic [7:0]  buf_wdata, buf_rdata;
    logic [7:0]  mem [0:16383];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit         sel;
        bit         oe;
        bit         we;
        bit         chk_addr;
        logic [13:0] xaddr;
        logic [7:0]  xdata;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    hwo_overlay uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rw(bus_rw),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_oe(bus_oe), .ext_sel_n(ext_sel_n), .buf_addr(buf_addr),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    assign buf_rdata = mem[buf_addr];
    always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

    function automatic logic [7:0] pat(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    task automatic access(input bit rw, input logic [15:0] a, input logic [7:0] d,
                          input bit sel, input bit oe, input bit we, input bit ca,
                          input logic [13:0] xa, input logic [7:0] xd, input string tag);
        exp_t e;
        @(posedge clk); #1;
        e.sel = sel; e.oe = oe; e.we = we; e.chk_addr = ca;
        e.xaddr = xa; e.xdata = rw ? xd : d; e.tag = tag;
        sb.push_back(e);
        bus_rw = rw; bus_addr = a; bus_wdata = d; bus_valid = 1'b1;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input bit sel, input bit ca,
                      input logic [13:0] xa, input logic [7:0] xd, input string tag);
        access(1'b1, a, 8'h00, sel, sel, 1'b0, ca, xa, xd, tag);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit sel,
                      input bit we, input logic [13:0] xa, input string tag);
        access(1'b0, a, d, sel, 1'b0, we, we, xa, 8'h00, tag);
    endtask

    // Monitor: compare each data phase against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && bus_valid && sb.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb.pop_front();
            bad = (ext_sel_n != !e.sel) || (bus_oe != e.oe) || (buf_we != e.we);
            if (e.chk_addr && buf_addr != e.xaddr) bad = 1'b1;
            if (e.oe && bus_rdata != e.xdata) bad = 1'b1;
            if (e.we && buf_wdata != e.xdata) bad = 1'b1;
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s: sel_n=%b oe=%b we=%b addr=%h data=%h / expected sel_n=%b oe=%b we=%b addr=%h data=%h",
                         e.tag, ext_sel_n, bus_oe, buf_we, buf_addr,
                         e.oe ? bus_rdata : buf_wdata,
                         !e.sel, e.oe, e.we, e.xaddr, e.xdata);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete / expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16384; i++) mem[i] = pat(i);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (!(ext_sel_n && !bus_oe && !buf_we)) begin
            errors++;
            $display("FAIL R1: sel_n=%b oe=%b we=%b / expected 1 0 0", ext_sel_n, bus_oe, buf_we);
        end
        // R2: deselected device ignores its window
        rd(16'hD804, 0, 0, 0, 8'h00, "R2 deselected read");
        wr(16'hD1FF, 8'h01, 0, 0, 0, "R2 select write");
        rd(16'hD804, 1, 0, 0, 8'h00, "R1 ctrl reset zero");
        // R3: staged low byte, commit on high byte
        wr(16'hD800, 8'h40, 1, 0, 0, "R3 low stage");
        rd(16'hD800, 1, 0, 0, 8'h00, "R3 staged not visible");
        wr(16'hD801, 8'h10, 1, 0, 0, "R3 low commit");
        rd(16'hD800, 1, 0, 0, 8'h40, "R3 low lo readback");
        rd(16'hD801, 1, 0, 0, 8'h10, "R3 low hi readback");
        wr(16'hD802, 8'h40, 1, 0, 0, "R3 up stage");
        wr(16'hD803, 8'h12, 1, 0, 0, "R3 up commit");
        // R8: disabled overlay
        rd(16'h1050, 0, 0, 0, 8'h00, "R8 disabled no overlay");
        wr(16'hD804, 8'h8F, 1, 0, 0, "R8 enable 16-bit mask");
        // R6/R4/R5 reads
        rd(16'h1040, 1, 1, 14'h0000, pat(0), "R6 read at lower bound");
        rd(16'h1239, 1, 1, 14'h01F9, pat(14'h1F9), "R5 read near top");
        rd(16'h1240, 0, 0, 0, 8'h00, "R4 upper exclusive");
        rd(16'h103F, 0, 0, 0, 8'h00, "R4 below lower");
        // R7 write then read back
        wr(16'h1100, 8'hA5, 1, 1, 14'h00C0, "R7 overlay write");
        rd(16'h1100, 1, 1, 14'h00C0, 8'hA5, "R7 written byte readback");
        // R10 idle
        @(negedge clk);
        checks++;
        if (!(ext_sel_n && !bus_oe && !buf_we)) begin
            errors++;
            $display("FAIL R10: sel_n=%b oe=%b we=%b / expected 1 0 0", ext_sel_n, bus_oe, buf_we);
        end
        // R2: deselect, ignored register write, reselect
        wr(16'hD1FF, 8'h00, 0, 0, 0, "R2 deselect");
        rd(16'h1100, 0, 0, 0, 8'h00, "R2 no overlay when deselected");
        wr(16'hD804, 8'h00, 0, 0, 0, "R2 ignored ctrl write");
        wr(16'hD1FF, 8'h01, 0, 0, 0, "R2 reselect");
        rd(16'hD804, 1, 0, 0, 8'h8F, "R2 ctrl unchanged");
        // R5 narrower mask
        wr(16'hD804, 8'h87, 1, 0, 0, "R5 8-bit mask");
        rd(16'h1150, 1, 1, 14'h0010, pat(14'h10), "R5 masked index");
        // R4 empty window
        wr(16'hD802, 8'h00, 1, 0, 0, "R4 up stage");
        wr(16'hD803, 8'h10, 1, 0, 0, "R4 up below low");
        rd(16'h1040, 0, 0, 0, 8'h00, "R4 empty window");
        // R9 device window priority over overlapping overlay
        wr(16'hD800, 8'h00, 1, 0, 0, "R9 low stage");
        wr(16'hD801, 8'hD0, 1, 0, 0, "R9 low commit");
        wr(16'hD802, 8'h00, 1, 0, 0, "R9 up stage");
        wr(16'hD803, 8'hE0, 1, 0, 0, "R9 up commit");
        rd(16'hD100, 1, 1, 14'h0000, pat(0), "R9 overlay below device window");
        rd(16'hD804, 1, 0, 0, 8'h87, "R9 register wins over overlay");
        rd(16'hD900, 1, 0, 0, 8'h00, "R9 unused offset reads zero");
        wr(16'hD9AB, 8'h33, 1, 0, 0, "R9 no buffer write in device window");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule